// File: doc/BRIEF.md
# Spare-Column Row Shift Remapper

This block translates logical cell positions in a grid of logic blocks into physical positions in an array that has one more column than the logical width. The rightmost physical column is held in reserve. When a row holds a faulty cell, every logical cell at or to the right of the fault moves one physical position to the right. The faulty cell is skipped, and the spare column takes the last logical cell. A row with no fault leaves the spare column unused.

A fault map is loaded through a write port that takes a row and a physical column. Each row holds one entry, made of a valid bit and a column index. A single spare column can repair only one fault per row. A second fault written to a row that already has one raises that row's unrepairable flag, and the first entry stays in place.

The block has three outputs. A flat vector carries the per-row bypass mux selects. A combinational lookup port returns the physical column for a logical row and column. The third output is the vector of unrepairable flags. A synchronous clear empties the whole map.

Top module: `spare_col_remap`

## Requirements
- R1: After reset, or in the cycle after `clr` is high at a clock edge, no row holds a fault. All `unrep` bits are 0, all `sel` bits are 0, and `lk_phys` equals `lk_col`.
- R2: A write with `wr_en` high, a row below ROWS and a column no greater than COLS stores that column as the row's fault. The fault takes effect from the clock edge that samples the write.
- R3: `lk_phys` is combinational. It equals `lk_col + 1` when row `lk_row` holds a fault and `lk_col` is at or above the fault column. Otherwise it equals `lk_col`.
- R4: Bit `r*COLS + i` of `sel` is 1 exactly when row r holds a fault and i is at or above its fault column. This means logical cell i of row r takes physical position i+1.
- R5: A write to a row that already holds a fault sets bit r of `unrep` and keeps the first fault column. The flag stays set until a clear.
- R6: A fault column equal to COLS, which is the spare, is accepted and causes no shift. A fault column greater than COLS is ignored and leaves the map unchanged.
- R7: When `clr` and `wr_en` are both high at the same edge, the clear wins and no fault is stored.
- R8: In a row with no fault, no logical column maps to physical column COLS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the fault map and flags |
| wr_en | input | 1 | Fault write strobe |
| wr_row | input | RW | Row of the fault being written |
| wr_col | input | CW | Physical column of the fault being written |
| lk_row | input | RW | Lookup logical row |
| lk_col | input | CW | Lookup logical column |
| lk_phys | output | CW | Physical column for the lookup |
| sel | output | ROWS*COLS | Bypass mux selects, bit r*COLS+i for row r, cell i |
| unrep | output | ROWS | Per-row unrepairable flag |

## Verification
The lookup range check assumes that `lk_col` is a valid logical column, meaning below COLS. It says nothing about lookups outside that range. The write checks assume that `wr_row` addresses an existing row. The stimulus keeps to both conditions: every lookup stays inside the logical width, and every row index stays inside the array. Fault columns are the one input allowed to go out of range, past COLS, so that the ignore rule is exercised.

// File: rtl/spare_col_remap.sv
module spare_col_remap #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [((ROWS>1)?$clog2(ROWS):1)-1:0] wr_row,
  input  logic [$clog2(COLS+1)-1:0] wr_col,
  input  logic [((ROWS>1)?$clog2(ROWS):1)-1:0] lk_row,
  input  logic [$clog2(COLS+1)-1:0] lk_col,
  output logic [$clog2(COLS+1)-1:0] lk_phys,
  output logic [ROWS*COLS-1:0]   sel,
  output logic [ROWS-1:0]        unrep
);
  localparam int CW = $clog2(COLS+1);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [ROWS-1:0] vld_q, unrep_q;
  logic [CW-1:0]   idx_q [ROWS];

  wire wr_ok = wr_en && (wr_col <= CW'(COLS)) && (int'(wr_row) < ROWS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      unrep_q <= '0;
      for (int r = 0; r < ROWS; r++) idx_q[r] <= '0;
    end else if (clr) begin
      vld_q   <= '0;
      unrep_q <= '0;
      for (int r = 0; r < ROWS; r++) idx_q[r] <= '0;
    end else if (wr_ok) begin
      if (vld_q[wr_row]) unrep_q[wr_row] <= 1'b1;
      else begin
        vld_q[wr_row] <= 1'b1;
        idx_q[wr_row] <= wr_col;
      end
    end
  end

  wire hit = vld_q[lk_row] && (lk_col >= idx_q[lk_row]);
  assign lk_phys = lk_col + CW'(hit);
  assign unrep   = unrep_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar i = 0; i < COLS; i++) begin : g_cell
      assign sel[r*COLS + i] = vld_q[r] && (CW'(i) >= idx_q[r]);
    end
    wire [COLS-1:0] row_sel = sel[r*COLS +: COLS];
    // R4: once a row starts shifting, every higher cell shifts too
    a_r4_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
      ((row_sel << 1) & ~row_sel) == '0);
  end

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sel == '0 && unrep == '0));

  a_r3_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_col < CW'(COLS)) |-> (lk_phys == lk_col || lk_phys == lk_col + CW'(1)));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((unrep & $past(unrep)) == $past(unrep)));

  a_r5_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !clr && vld_q[wr_row]) |=>
      (idx_q[$past(wr_row)] == $past(idx_q[wr_row]) && unrep[$past(wr_row)]));

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && wr_en) |=> (vld_q == '0));
endmodule

// File: tb/spare_col_remap_bench.sv
module spare_col_remap_bench;
  localparam int ROWS = 8, COLS = 8, CW = 4, RW = 3;

  logic clk = 0, rst_n = 0, clr = 0, wr_en = 0;
  logic [RW-1:0] wr_row = 0, lk_row = 0;
  logic [CW-1:0] wr_col = 0, lk_col = 0;
  logic [CW-1:0] lk_phys;
  logic [ROWS*COLS-1:0] sel;
  logic [ROWS-1:0] unrep;
  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spare_col_remap #(.ROWS(ROWS), .COLS(COLS)) u_spare_col_remap (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_row(wr_row),
    .wr_col(wr_col), .lk_row(lk_row), .lk_col(lk_col), .lk_phys(lk_phys),
    .sel(sel), .unrep(unrep));

  // {row[3:0], col[3:0], expected phys[3:0]} with the fault map loaded below
  localparam logic [11:0] LUT [14] = '{
    12'h001, 12'h078, 12'h122, 12'h134, 12'h178, 12'h266, 12'h278,
    12'h377, 12'h400, 12'h477, 12'h533, 12'h545, 12'h567, 12'h655};

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(int r, int c, bit with_clr = 0);
    @(negedge clk);
    wr_en = 1; wr_row = RW'(r); wr_col = CW'(c); clr = with_clr;
    @(negedge clk);
    wr_en = 0; clr = 0;
  endtask

  task automatic look(string req, int r, int c, int exp);
    lk_row = RW'(r); lk_col = CW'(c);
    #1 chk(req, 64'(lk_phys), 64'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset unrep", 64'(unrep), 0);
    chk("R1 reset sel", 64'(sel), 0);
    look("R1 reset lookup", 3, 5, 5);

    wr(0, 0); wr(1, 3); wr(2, 7); wr(3, 8); wr(5, 4); wr(5, 6);
    for (int k = 0; k < 14; k++)
      look("R2 R3 R8 table", int'(LUT[k][11:8]), int'(LUT[k][7:4]), int'(LUT[k][3:0]));

    chk("R4 row1 sel", 64'(sel[1*COLS +: COLS]), 64'h F8);
    chk("R4 row2 sel", 64'(sel[2*COLS +: COLS]), 64'h 80);
    chk("R4 row0 sel", 64'(sel[0 +: COLS]), 64'h FF);
    chk("R6 spare fault no shift", 64'(sel[3*COLS +: COLS]), 0);
    chk("R8 empty row sel", 64'(sel[4*COLS +: COLS]), 0);
    chk("R5 keep first sel", 64'(sel[5*COLS +: COLS]), 64'h F0);
    chk("R5 unrep flag", 64'(unrep), 64'h20);

    wr(6, 9);
    look("R6 ignored column", 6, 5, 5);
    chk("R6 ignored sel", 64'(sel[6*COLS +: COLS]), 0);
    wr(6, 2);
    look("R6 later write valid", 6, 2, 3);
    chk("R6 no unrep after ignored", 64'(unrep), 64'h20);
    repeat (3) @(negedge clk);
    chk("R5 sticky", 64'(unrep), 64'h20);

    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    chk("R1 clear unrep", 64'(unrep), 0);
    chk("R1 clear sel", 64'(sel), 0);
    look("R1 clear lookup", 1, 5, 5);

    wr(4, 1, 1);
    chk("R7 clear wins sel", 64'(sel), 0);
    look("R7 clear wins lookup", 4, 3, 3);
    wr(4, 1);
    look("R2 after clear", 4, 0, 0);
    look("R2 after clear shifted", 4, 1, 2);
    chk("R4 row4 sel", 64'(sel[4*COLS +: COLS]), 64'h FE);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule